// File: doc/BRIEF.md
# Spatial Random Dither Unit

This unit lowers the precision of a three-component pixel stream from a 12-bit internal width to either 6 or 8 bits per component. Each component first gets a pseudo-random addend as wide as the bits about to be dropped. The sum saturates at full scale and is then truncated. The reduced value appears in the low bits of each output component, and the bits above it are zero. Every channel draws its noise from its own 28-bit linear feedback shift register, and each register starts from a programmable seed.

Configuration inputs are plain, static levels. They select enable, depth, per-channel polynomials, per-frame reseeding and a high-pass shaping of the noise. Pixels arrive on a valid/ready stream with frame-start and line-start sideband bits. Those bits are meaningful only on the beat where the pixel is accepted. The output is a single register stage with the same valid/ready handshake and a latency of one cycle. An input beat is accepted when `in_valid` and `in_ready` are both high at a clock edge. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While the output is stalled (`out_valid` high, `out_ready` low), the output data holds.

Top module: `dith_spatial`

## Requirements
- R1: An accepted pixel appears on the output with `out_valid` high after the next clock edge. `in_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid` and the output components stay unchanged. After reset, `out_valid` is low.
- R2: When `cfg_en` is low, or `cfg_depth` is 2 or 3, each output component equals its 12-bit input unchanged. The noise generators still advance.
- R3: Depth code 0 gives a 6-bit addend and outputs bits [11:6] of the saturated sum in bits [5:0], with bits [11:6] zero. Depth code 1 gives a 4-bit addend and outputs bits [11:4] of the sum in bits [7:0], with bits [11:8] zero.
- R4: The sum of a component and its addend saturates at 4095 and never wraps.
- R5: Each generator is a Fibonacci register s[27:0]. One step gives {s[26:0], s[27]^s[k-1]}, where x^28+x^k+1 is the channel's polynomial. The raw noise for a pixel is the low 6 (depth 0) or 4 (depth 1) bits of the current state. The state steps once per accepted pixel.
- R6: With `cfg_rgb_rand` low, all channels use k=3. With it high, R uses k=3, G uses k=9 and B uses k=13.
- R7: While `rst` is high, each generator loads its seed. A seed of zero is replaced by 1, and the same replacement applies to every reload value.
- R8: With `cfg_frame_rand` high, an accepted pixel with `in_frame_start` high uses, as its current state, seed XOR {24'b0, c[1:0], c[3:2]}. Here c is the 4-bit frame counter before that pixel. The counter then increments and wraps from 15 to 0. With `cfg_frame_rand` low, frame starts neither reload the generators nor change the counter. The counter is 0 after reset.
- R9: With `cfg_hp_en` high, the addend is raw-prev when raw ≥ prev, and 0 otherwise. Here prev is that channel's raw noise from the previous accepted pixel. prev is 0 after reset and for a pixel accepted with `in_line_start` high. With `cfg_hp_en` low, the addend is the raw noise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, loads seeds |
| cfg_en | input | 1 | Dither enable |
| cfg_depth | input | 2 | 0: 6 bits, 1: 8 bits, 2/3: bypass |
| cfg_rgb_rand | input | 1 | Per-channel polynomials |
| cfg_frame_rand | input | 1 | Reseed at each frame start |
| cfg_hp_en | input | 1 | High-pass shaping of noise |
| cfg_seed_r | input | 28 | Red generator seed |
| cfg_seed_g | input | 28 | Green generator seed |
| cfg_seed_b | input | 28 | Blue generator seed |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with valid |
| in_frame_start | input | 1 | First pixel of a frame |
| in_line_start | input | 1 | First pixel of a line |
| in_r | input | 12 | Red component |
| in_g | input | 12 | Green component |
| in_b | input | 12 | Blue component |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Downstream ready |
| out_r | output | 12 | Reduced red |
| out_g | output | 12 | Reduced green |
| out_b | output | 12 | Reduced blue |

## Verification
The bench drives long streams with irregular valid and ready patterns and keeps its own model of every generator. A design that stepped the generators on stalled or idle cycles would drift away from the model after the first bubble. Components at or near 4095 target the saturation rule, where a wrapping adder would produce near-zero outputs. The run is long enough for the frame counter to pass its wrap from 15 to 0, so a wrong bit permutation or a missing wrap shows up as wrong reseeds. Zero seeds, the bypass depth codes, per-channel polynomials and line-start clearing of the high-pass history are each exercised in their own run.

// File: rtl/dith_pkg.sv
package dith_pkg;
  localparam int LFSR_W = 28;

  typedef enum logic [1:0] {
    DEPTH_NARROW = 2'd0,
    DEPTH_WIDE   = 2'd1,
    DEPTH_RSVD2  = 2'd2,
    DEPTH_RSVD3  = 2'd3
  } depth_e;

  // an all-zero state would lock the register, so substitute 1
  function automatic logic [LFSR_W-1:0] no_zero(input logic [LFSR_W-1:0] v);
    return (v == '0) ? {{(LFSR_W-1){1'b0}}, 1'b1} : v;
  endfunction
endpackage

// File: rtl/dith_lfsr.sv
module dith_lfsr #(
  parameter int LW      = 28,
  parameter int TAP_ALT = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [LW-1:0] seed,
  input  logic          use_alt,
  input  logic          adv,
  input  logic          reload,
  input  logic [LW-1:0] reload_val,
  output logic [LW-1:0] cur
);
  localparam int TAP_BASE = 3;

  logic [LW-1:0] state;
  logic          fb;

  assign cur = reload ? reload_val : state;
  assign fb  = cur[LW-1] ^ (use_alt ? cur[TAP_ALT-1] : cur[TAP_BASE-1]);

  always_ff @(posedge clk) begin
    if (rst)      state <= dith_pkg::no_zero(seed);
    else if (adv) state <= {cur[LW-2:0], fb};
  end

  // R7: the generator never reaches the locked all-zero state
  a_r7_state_nonzero: assert property (@(posedge clk) disable iff (rst)
    state != '0);
endmodule

// File: rtl/dith_shaper.sv
module dith_shaper #(
  parameter int KMAX = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            adv,
  input  logic            line_start,
  input  logic            hp_en,
  input  logic [KMAX-1:0] raw,
  output logic [KMAX-1:0] addend
);
  logic [KMAX-1:0] prev_q;
  logic [KMAX-1:0] prev_eff;

  assign prev_eff = line_start ? '0 : prev_q;

  always_comb begin
    if (!hp_en)               addend = raw;
    else if (raw >= prev_eff) addend = raw - prev_eff;
    else                      addend = '0;
  end

  always_ff @(posedge clk) begin
    if (rst)      prev_q <= '0;
    else if (adv) prev_q <= raw;
  end

  // R9: shaped noise never exceeds the raw noise
  a_r9_hp_bound: assert property (@(posedge clk) disable iff (rst)
    addend <= raw);
endmodule

// File: rtl/dith_reduce.sv
module dith_reduce #(
  parameter int CW   = 12,
  parameter int KN   = 6,
  parameter int KW   = 4,
  parameter int KMAX = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            active,
  input  logic            narrow,
  input  logic [CW-1:0]   pix,
  input  logic [KMAX-1:0] addend,
  output logic [CW-1:0]   res
);
  logic [CW:0]   sum;
  logic [CW-1:0] sat;

  assign sum = {1'b0, pix} + {{(CW+1-KMAX){1'b0}}, addend};
  assign sat = sum[CW] ? {CW{1'b1}} : sum[CW-1:0];

  always_comb begin
    if (!active)     res = pix;
    else if (narrow) res = {{KN{1'b0}}, sat[CW-1:KN]};
    else             res = {{KW{1'b0}}, sat[CW-1:KW]};
  end

  // R4: saturated sum never falls below the input
  always_ff @(posedge clk) begin
    if (!rst) a_r4_no_wrap: assert (sat >= pix);
  end
endmodule

// File: rtl/dith_spatial.sv
module dith_spatial #(
  parameter int CW     = 12,
  parameter int LW     = 28,
  parameter int NARROW = 6,
  parameter int WIDE   = 8,
  parameter int FCW    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_en,
  input  logic [1:0]    cfg_depth,
  input  logic          cfg_rgb_rand,
  input  logic          cfg_frame_rand,
  input  logic          cfg_hp_en,
  input  logic [LW-1:0] cfg_seed_r,
  input  logic [LW-1:0] cfg_seed_g,
  input  logic [LW-1:0] cfg_seed_b,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_frame_start,
  input  logic          in_line_start,
  input  logic [CW-1:0] in_r,
  input  logic [CW-1:0] in_g,
  input  logic [CW-1:0] in_b,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [CW-1:0] out_r,
  output logic [CW-1:0] out_g,
  output logic [CW-1:0] out_b
);
  import dith_pkg::*;

  localparam int KN   = CW - NARROW;
  localparam int KW   = CW - WIDE;
  localparam int KMAX = (KN > KW) ? KN : KW;
  localparam int NCH  = 3;
  localparam int HF   = FCW / 2;

  logic            accept;
  logic            active;
  logic            narrow;
  logic            frame_reload;
  logic [FCW-1:0]  fcnt;
  logic [FCW-1:0]  perm;

  logic [LW-1:0]   seed_a [NCH];
  logic [CW-1:0]   pix_a  [NCH];
  logic [CW-1:0]   res_a  [NCH];
  logic [CW-1:0]   q_a    [NCH];

  logic            q_active, q_narrow;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;
  assign narrow   = (depth_e'(cfg_depth) == DEPTH_NARROW);
  assign active   = cfg_en && (narrow || depth_e'(cfg_depth) == DEPTH_WIDE);
  assign frame_reload = accept && in_frame_start && cfg_frame_rand;
  assign perm     = {fcnt[HF-1:0], fcnt[FCW-1:HF]};

  assign seed_a[0] = cfg_seed_r;
  assign seed_a[1] = cfg_seed_g;
  assign seed_a[2] = cfg_seed_b;
  assign pix_a[0]  = in_r;
  assign pix_a[1]  = in_g;
  assign pix_a[2]  = in_b;

  always_ff @(posedge clk) begin
    if (rst)               fcnt <= '0;
    else if (frame_reload) fcnt <= fcnt + 1'b1;
  end

  genvar ch;
  generate
    for (ch = 0; ch < NCH; ch++) begin : g_chan
      localparam int TAP = (ch == 0) ? 3 : (ch == 1) ? 9 : 13;
      logic [LW-1:0]   cur;
      logic [LW-1:0]   rl_val;
      logic [KMAX-1:0] raw;
      logic [KMAX-1:0] addend;

      assign rl_val = no_zero(seed_a[ch] ^ {{(LW-FCW){1'b0}}, perm});
      assign raw    = narrow ? cur[KMAX-1:0]
                             : {{(KMAX-KW){1'b0}}, cur[KW-1:0]};

      dith_lfsr #(.LW(LW), .TAP_ALT(TAP)) u_lfsr (
        .clk(clk), .rst(rst), .seed(seed_a[ch]), .use_alt(cfg_rgb_rand),
        .adv(accept), .reload(frame_reload), .reload_val(rl_val), .cur(cur)
      );

      dith_shaper #(.KMAX(KMAX)) u_shape (
        .clk(clk), .rst(rst), .adv(accept), .line_start(in_line_start),
        .hp_en(cfg_hp_en), .raw(raw), .addend(addend)
      );

      dith_reduce #(.CW(CW), .KN(KN), .KW(KW), .KMAX(KMAX)) u_red (
        .clk(clk), .rst(rst), .active(active), .narrow(narrow),
        .pix(pix_a[ch]), .addend(addend), .res(res_a[ch])
      );

      always_ff @(posedge clk) begin
        if (accept) q_a[ch] <= res_a[ch];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      q_active  <= 1'b0;
      q_narrow  <= 1'b0;
    end else if (accept) begin
      out_valid <= 1'b1;
      q_active  <= active;
      q_narrow  <= narrow;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assign out_r = q_a[0];
  assign out_g = q_a[1];
  assign out_b = q_a[2];

  // R1: a stalled output holds its beat
  a_r1_stall_hold: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_r)
                                && $stable(out_g) && $stable(out_b));

  // R1: an accepted beat is presented on the next cycle
  a_r1_accept_valid: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready |=> out_valid);

  // R8: the frame counter steps only on reseeding frame starts
  a_r8_counter_step: assert property (@(posedge clk) disable iff (rst)
    frame_reload |=> fcnt == $past(fcnt) + 1'b1);

  a_r8_counter_hold: assert property (@(posedge clk) disable iff (rst)
    !frame_reload |=> $stable(fcnt));

  // R3: bits above the reduced field are zero in dither modes
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (rst)
    out_valid && q_active |->
      (q_narrow ? ((out_r >> NARROW) == '0 && (out_g >> NARROW) == '0
                   && (out_b >> NARROW) == '0)
                : ((out_r >> WIDE) == '0 && (out_g >> WIDE) == '0
                   && (out_b >> WIDE) == '0)));
endmodule

// File: tb/dith_spatial_test.sv
module dith_spatial_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_en = 1'b0;
  logic [1:0]  cfg_depth = 2'd0;
  logic        cfg_rgb_rand = 1'b0, cfg_frame_rand = 1'b0, cfg_hp_en = 1'b0;
  logic [27:0] cfg_seed_r = 28'h1, cfg_seed_g = 28'h1, cfg_seed_b = 28'h1;
  logic        in_valid = 1'b0, in_frame_start = 1'b0, in_line_start = 1'b0;
  logic [11:0] in_r = '0, in_g = '0, in_b = '0;
  logic        out_ready = 1'b0;
  logic        in_ready, out_valid;
  logic [11:0] out_r, out_g, out_b;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  dith_spatial uut (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_depth(cfg_depth),
    .cfg_rgb_rand(cfg_rgb_rand), .cfg_frame_rand(cfg_frame_rand),
    .cfg_hp_en(cfg_hp_en), .cfg_seed_r(cfg_seed_r), .cfg_seed_g(cfg_seed_g),
    .cfg_seed_b(cfg_seed_b), .in_valid(in_valid), .in_ready(in_ready),
    .in_frame_start(in_frame_start), .in_line_start(in_line_start),
    .in_r(in_r), .in_g(in_g), .in_b(in_b), .out_valid(out_valid),
    .out_ready(out_ready), .out_r(out_r), .out_g(out_g), .out_b(out_b)
  );

  // reference model state
  logic [27:0] m_st [3];
  logic [5:0]  m_prev [3];
  logic [3:0]  m_cnt;
  logic [35:0] expq [0:1023];
  int head, tail;

  function automatic logic [27:0] nz(input logic [27:0] v);
    return (v == 0) ? 28'h1 : v;
  endfunction

  function automatic int tap_of(input int ch, input logic alt);
    if (!alt || ch == 0) return 3;
    return (ch == 1) ? 9 : 13;
  endfunction

  task automatic check(input bit ok, input string req, input logic [35:0] act,
                       input logic [35:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_push(input logic [11:0] p [3], input bit fs, input bit ls);
    logic [27:0] seeds [3];
    logic [11:0] e [3];
    seeds[0] = cfg_seed_r; seeds[1] = cfg_seed_g; seeds[2] = cfg_seed_b;
    for (int c = 0; c < 3; c++) begin
      logic [27:0] cur;
      logic [5:0]  raw, prv, add;
      int k, t, s;
      bit act, nar;
      nar = (cfg_depth == 2'd0);
      act = cfg_en && (cfg_depth <= 2'd1);
      k = nar ? 6 : 4;
      if (fs && cfg_frame_rand)
        cur = nz(seeds[c] ^ {24'b0, m_cnt[1:0], m_cnt[3:2]});
      else
        cur = m_st[c];
      raw = nar ? cur[5:0] : {2'b0, cur[3:0]};
      prv = ls ? 6'd0 : m_prev[c];
      if (!cfg_hp_en) add = raw;
      else add = (raw >= prv) ? raw - prv : 6'd0;
      s = int'(p[c]) + int'(add);
      if (s > 4095) s = 4095;
      e[c] = act ? 12'(s >> k) : p[c];
      t = tap_of(c, cfg_rgb_rand);
      m_st[c] = {cur[26:0], cur[27] ^ cur[t-1]};
      m_prev[c] = raw;
    end
    if (fs && cfg_frame_rand) m_cnt = m_cnt + 1'b1;
    expq[tail % 1024] = {e[0], e[1], e[2]};
    tail++;
  endtask

  task automatic run_cfg(input string req, input bit en, input logic [1:0] dp,
                         input bit rgb, input bit fr, input bit hp,
                         input logic [27:0] sr, input logic [27:0] sg,
                         input logic [27:0] sb, input int npix);
    int sent, cyc;
    logic [35:0] held;
    bit was_stall;
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; out_ready = 1'b0;
    cfg_en = en; cfg_depth = dp; cfg_rgb_rand = rgb; cfg_frame_rand = fr;
    cfg_hp_en = hp; cfg_seed_r = sr; cfg_seed_g = sg; cfg_seed_b = sb;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    m_st[0] = nz(sr); m_st[1] = nz(sg); m_st[2] = nz(sb);
    for (int c = 0; c < 3; c++) m_prev[c] = 6'd0;
    m_cnt = 4'd0; head = 0; tail = 0;
    #1;
    check(out_valid == 1'b0, "R1 reset", {35'b0, out_valid}, 36'b0);
    sent = 0; cyc = 0; was_stall = 0; held = '0;
    while ((sent < npix || head != tail) && cyc < 20000) begin
      logic [11:0] p [3];
      @(negedge clk);
      if (was_stall)
        check({out_r, out_g, out_b} == held && out_valid,
              {req, " R1 stall"}, {out_r, out_g, out_b}, held);
      out_ready = ((cyc * 7 + 3) % 5) != 0;
      in_valid  = (sent < npix) && ((cyc % 3) != 1);
      p[0] = (sent % 5 == 0) ? 12'd4095 : 12'((sent * 523 + 17) % 4096);
      p[1] = 12'(4095 - ((sent * 97) % 64));
      p[2] = (sent % 7 == 0) ? 12'd4090 : 12'((sent * 11) % 4096);
      in_r = p[0]; in_g = p[1]; in_b = p[2];
      in_frame_start = (sent % 8 == 0);
      in_line_start  = (sent % 4 == 0);
      #1;
      check(in_ready == (!out_valid || out_ready), "R1 ready",
            {35'b0, in_ready}, {35'b0, (!out_valid || out_ready)});
      if (out_valid && out_ready) begin
        check(head != tail && {out_r, out_g, out_b} == expq[head % 1024],
              req, {out_r, out_g, out_b}, expq[head % 1024]);
        head++;
      end
      was_stall = out_valid && !out_ready;
      held = {out_r, out_g, out_b};
      if (in_valid && in_ready) begin
        model_push(p, in_frame_start, in_line_start);
        sent++;
      end
      cyc++;
    end
    if (cyc >= 20000) check(1'b0, {req, " watchdog"}, 36'(cyc), 36'(npix));
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #1_000_000;
    check(1'b0, "watchdog", '0, '0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // R2: disabled and unsupported depth codes pass data unchanged
    run_cfg("R2 off",    0, 2'd0, 0, 0, 0, 28'h1234567, 28'h0abcdef, 28'h5555555, 60);
    run_cfg("R2 depth2", 1, 2'd2, 1, 1, 1, 28'h1234567, 28'h0abcdef, 28'h5555555, 60);
    run_cfg("R2 depth3", 1, 2'd3, 0, 0, 0, 28'h7654321, 28'h0000fff, 28'h0aaaaaa, 40);
    // R3 R4 R5 R6: base polynomial, 6-bit output
    run_cfg("R3 R5 narrow", 1, 2'd0, 0, 0, 0, 28'h8f3a5c1, 28'h0123457, 28'hfedcba9, 150);
    // R3 R6: per-channel polynomials, 8-bit output
    run_cfg("R6 wide rgb", 1, 2'd1, 1, 0, 0, 28'h8f3a5c1, 28'h0123457, 28'hfedcba9, 150);
    // R9: high-pass shaping with line-start clearing
    run_cfg("R9 hp", 1, 2'd0, 1, 0, 1, 28'h3c3c3c3, 28'h7777777, 28'h0000001, 150);
    // R7 R8: zero seed and frame reseeding past the counter wrap
    run_cfg("R7 R8 frame", 1, 2'd1, 0, 1, 0, 28'h00000a5, 28'h0000000, 28'h000000f, 200);
    run_cfg("R8 R9 frame hp", 1, 2'd0, 1, 1, 1, 28'h0000000, 28'h1f00f0f, 28'h000000c, 200);
    // R4: saturation is covered by the 4095 and 4090 components in every run
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule